// File: doc/BRIEF.md
# Dual-Clock Stream FIFO

This block carries data words from a producer clocked by one clock to a consumer clocked by an unrelated clock. Both sides speak valid/ready. A word offered on the input is taken on a rising write-clock edge where `in_valid` and `in_ready` are both high. A word offered while `in_ready` is low is discarded, not held: the producer must not expect a retry. The read pointer is passed to the write domain in Gray code, and the write pointer to the read domain, each through a two-flop synchronizer. The storage is a plain behavioural array, written on the write clock and read on the read clock.

The read side has two modes, chosen by a parameter. In look-ahead mode (`FWFT=1`) the oldest word is placed on `out_data` without being asked for. The consumer takes it with `out_ready`, and back-pressure from `out_ready` low freezes both the word and `out_valid`. In request mode (`FWFT=0`), `out_valid` means only that stored words exist. A cycle with `out_valid` and `out_ready` both high asks for one word, and that word shows up on `out_data` after a fixed latency. A second parameter adds one output register stage.

Each side reports how many words it sees stored, and raises a threshold flag that is set by its own programmable offset. A storage slot is released only once its word has left the output stages. Words held in those stages therefore count toward both the capacity and the read-side count.

Top module: `dc_fifo_stream`

## Requirements
- R1: While both resets are held, and just after they release, `out_valid`=0, `in_ready`=1, `wr_count`=0, `rd_count`=0, `rd_aempty`=1 and `wr_afull`=0.
- R2: A word is stored exactly when `in_valid` and `in_ready` are high at a write-clock edge. `in_ready` is low exactly when `wr_count` equals DEPTH, so an idle-read FIFO accepts exactly DEPTH words.
- R3: A word offered while `in_ready` is low is dropped. It never appears at the output, and it does not raise `wr_count`.
- R4: Words leave in the order they were accepted, with none lost and none repeated.
- R5: With `FWFT=1`, the oldest word is on `out_data` with `out_valid`=1 without any request. It is consumed on a read edge with `out_valid` and `out_ready` high. While `out_ready` is low, `out_valid` and `out_data` hold.
- R6: With `FWFT=0`, `out_valid`=1 means words are stored. A read edge with `out_valid` and `out_ready` high requests the oldest word, which is on `out_data` after 1+OUT_REG further read-clock edges.
- R7: With `OUT_REG=1`, the total number of words held, output stages included, never exceeds DEPTH. An idle-read FIFO accepts exactly DEPTH words.
- R8: `wr_afull` is 1 exactly when `wr_count` >= DEPTH - AF_OFF.
- R9: `rd_aempty` is 1 exactly when `rd_count` <= AE_OFF.
- R10: `wr_count` never exceeds DEPTH and is never below the number of accepted, not yet consumed words. Once both sides have been idle for a few read cycles, it equals that number.
- R11: `rd_count` includes words in the output stages and never exceeds the accepted, unconsumed words. `out_valid`=1 implies `rd_count`>=1, and `rd_count` may be nonzero while `out_valid`=0 as words move through the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| in_data | input | DATA_W | Word offered by the producer |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | FIFO can take a word (not full) |
| wr_count | output | log2(DEPTH)+1 | Stored words as seen from the write side |
| wr_afull | output | 1 | Write-side threshold flag |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| out_data | output | DATA_W | Word presented to the consumer |
| out_valid | output | 1 | Look-ahead: `out_data` valid; request mode: words stored |
| out_ready | input | 1 | Look-ahead: consumer takes the word; request mode: read request |
| rd_count | output | log2(DEPTH)+1 | Stored words as seen from the read side, output stages included |
| rd_aempty | output | 1 | Read-side threshold flag |

## Verification
The properties assume that both resets are applied together, so that the two pointer sets start equal. They also assume that `out_ready` and `in_valid` are known values at every clock edge, so the hold and drop properties look only at real handshakes. The stimulus applies both resets together only at the start. It drives every handshake input from the opposite clock edge, with known values. It varies how busy each side is, with fill-only, drain-only, balanced, producer-heavy and consumer-heavy phases. The count bounds are checked on each side's own clock, against a queue that runs ahead of the real pointers, so each bound is one-sided.

// File: rtl/dc_fifo_pkg.sv
package dc_fifo_pkg;
  localparam int unsigned SYNC_FLOPS = 2;

  function automatic bit depth_ok(int unsigned d);
    return (d >= 2) && ((d & (d - 1)) == 0);
  endfunction
endpackage

// File: rtl/dc_fifo_sync.sv
module dc_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = dc_fifo_pkg::SYNC_FLOPS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) s_q[i] <= '0;
    end else begin
      s_q[0] <= d;
      for (int i = 1; i < STAGES; i++) s_q[i] <= s_q[i-1];
    end
  end

  assign q = s_q[STAGES-1];
endmodule

// File: rtl/dc_fifo_g2b.sv
module dc_fifo_g2b #(
  parameter int W = 5
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin[i] = ^gray[W-1:i];
  end
endmodule

// File: rtl/dc_fifo_wr_side.sv
module dc_fifo_wr_side #(
  parameter int AW     = 4,
  parameter int AF_OFF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW:0]   rsync_gray,
  output logic          in_ready,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic [AW:0]   wr_count,
  output logic          wr_afull
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin_q, wgray_q, rsync_bin, wnext, wnext_g;

  dc_fifo_g2b #(.W(PW)) u_g2b (.gray(rsync_gray), .bin(rsync_bin));

  assign wr_count = wbin_q - rsync_bin;
  assign in_ready = (wr_count != PW'(DEPTH));
  assign wr_afull = (int'(wr_count) >= DEPTH - AF_OFF);
  assign push     = in_valid && in_ready;
  assign wnext    = wbin_q + 1'b1;
  assign wnext_g  = wnext ^ (wnext >> 1);
  assign waddr    = wbin_q[AW-1:0];
  assign wgray    = wgray_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wbin_q  <= wnext;
      wgray_q <= wnext_g;
    end
  end
endmodule

// File: rtl/dc_fifo_rd_side.sv
module dc_fifo_rd_side #(
  parameter int W       = 32,
  parameter int AW      = 4,
  parameter int AE_OFF  = 8,
  parameter bit FWFT    = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   wsync_gray,
  input  logic [W-1:0]  mem_q,
  input  logic          out_ready,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [AW:0]   rd_count,
  output logic          rd_aempty
);
  localparam int PW  = AW + 1;
  localparam int STG = OUT_REG ? 2 : 1;

  logic [PW-1:0] fetch_q, ret_q, ret_g_q, wsync_bin, ret_next;
  logic          mem_empty, fetch, retire;
  logic [W-1:0]  d_q [STG];

  dc_fifo_g2b #(.W(PW)) u_g2b (.gray(wsync_gray), .bin(wsync_bin));

  assign mem_empty = (fetch_q == wsync_bin);
  assign raddr     = fetch_q[AW-1:0];
  assign rgray     = ret_g_q;
  assign ret_next  = ret_q + 1'b1;
  assign rd_count  = wsync_bin - ret_q;
  assign rd_aempty = (int'(rd_count) <= AE_OFF);
  assign out_data  = d_q[STG-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= '0;
      ret_q   <= '0;
      ret_g_q <= '0;
    end else begin
      if (fetch) fetch_q <= fetch_q + 1'b1;
      if (retire) begin
        ret_q   <= ret_next;
        ret_g_q <= ret_next ^ (ret_next >> 1);
      end
    end
  end

  if (FWFT) begin : g_fwft
    logic [STG:0]   take;
    logic [STG-1:0] move, load, v_q;

    always_comb begin
      take[STG] = out_ready;
      for (int i = STG - 1; i >= 0; i--) begin
        move[i] = v_q[i] && take[i+1];
        take[i] = !v_q[i] || move[i];
      end
      load[0] = fetch;
      for (int i = 1; i < STG; i++) load[i] = move[i-1];
    end

    assign fetch     = !mem_empty && take[0];
    assign retire    = v_q[STG-1] && out_ready;
    assign out_valid = v_q[STG-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        for (int i = 0; i < STG; i++) d_q[i] <= '0;
      end else begin
        for (int i = 0; i < STG; i++) begin
          if (load[i]) v_q[i] <= 1'b1;
          else if (move[i]) v_q[i] <= 1'b0;
        end
        if (load[0]) d_q[0] <= mem_q;
        for (int i = 1; i < STG; i++) if (load[i]) d_q[i] <= d_q[i-1];
      end
    end
  end else begin : g_req
    assign fetch     = out_ready && !mem_empty;
    assign retire    = fetch;
    assign out_valid = !mem_empty;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < STG; i++) d_q[i] <= '0;
      end else begin
        if (fetch) d_q[0] <= mem_q;
        for (int i = 1; i < STG; i++) d_q[i] <= d_q[i-1];
      end
    end
  end
endmodule

// File: rtl/dc_fifo_stream.sv
module dc_fifo_stream #(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 16,
  parameter bit FWFT    = 1'b1,
  parameter bit OUT_REG = 1'b1,
  parameter int AF_OFF  = DEPTH / 2,
  parameter int AE_OFF  = DEPTH / 2
) (
  input  logic                       wr_clk,
  input  logic                       wr_rst_n,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       in_valid,
  output logic                       in_ready,
  output logic [$clog2(DEPTH):0]     wr_count,
  output logic                       wr_afull,
  input  logic                       rd_clk,
  input  logic                       rd_rst_n,
  output logic [DATA_W-1:0]          out_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [$clog2(DEPTH):0]     rd_count,
  output logic                       rd_aempty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  if (!dc_fifo_pkg::depth_ok(DEPTH)) begin : g_bad_depth
    $error("dc_fifo_stream: DEPTH must be a power of two and at least 2");
  end

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic              push;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;

  dc_fifo_wr_side #(.AW(AW), .AF_OFF(AF_OFF)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(in_valid), .rsync_gray(rgray_ws),
    .in_ready(in_ready), .push(push), .waddr(waddr), .wgray(wgray),
    .wr_count(wr_count), .wr_afull(wr_afull)
  );

  dc_fifo_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_rs));
  dc_fifo_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_ws));

  always_ff @(posedge wr_clk) begin
    if (push) mem[waddr] <= in_data;
  end

  assign mem_q = mem[raddr];

  dc_fifo_rd_side #(
    .W(DATA_W), .AW(AW), .AE_OFF(AE_OFF), .FWFT(FWFT), .OUT_REG(OUT_REG)
  ) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .wsync_gray(wgray_rs), .mem_q(mem_q),
    .out_ready(out_ready), .raddr(raddr), .rgray(rgray), .out_valid(out_valid),
    .out_data(out_data), .rd_count(rd_count), .rd_aempty(rd_aempty)
  );
endmodule

// File: rtl/dc_fifo_stream_chk.sv
module dc_fifo_stream_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter bit FWFT   = 1'b1
) (
  input logic                   wr_clk,
  input logic                   wr_rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [$clog2(DEPTH):0] wr_count,
  input logic                   rd_clk,
  input logic                   rd_rst_n,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [DATA_W-1:0]      out_data,
  input logic [$clog2(DEPTH):0] rd_count
);
  // R2
  accept_counts_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (in_valid && in_ready) |=> (wr_count != 0));

  // R3
  drop_no_growth_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (in_valid && !in_ready) |=> (wr_count <= $past(wr_count)));

  // R10
  wr_bound_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    int'(wr_count) <= DEPTH);

  // R11
  rd_bound_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    int'(rd_count) <= DEPTH);

  // R11
  rd_occupied_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    out_valid |-> (rd_count != 0));

  // R5
  hold_under_stall_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (FWFT && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind dc_fifo_stream dc_fifo_stream_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .FWFT(FWFT)
) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wr_count(wr_count), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .rd_count(rd_count)
);

// File: tb/dc_fifo_stream_bench.sv
`timescale 1ns/10ps
module dc_fifo_stream_bench;
  localparam int W     = 16;
  localparam int DEPTH = 16;
  localparam int AF    = 4;
  localparam int AE    = 3;
  localparam int AW    = $clog2(DEPTH);

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n, rd_rst_n;
  always #2.5  wr_clk = ~wr_clk;
  always #3.65 rd_clk = ~rd_clk;

  logic [W-1:0] da, db, oda, odb;
  logic va, vb, rdya, rdyb, ra, rb, afa, afb, aea, aeb, ova, ovb;
  logic [AW:0] wca, wcb, rca, rcb;

  dc_fifo_stream #(.DATA_W(W), .DEPTH(DEPTH), .FWFT(1'b1), .OUT_REG(1'b1),
    .AF_OFF(AF), .AE_OFF(AE)) u_dc_fifo_stream (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_data(da), .in_valid(va), .in_ready(rdya),
    .wr_count(wca), .wr_afull(afa), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .out_data(oda), .out_valid(ova), .out_ready(ra), .rd_count(rca), .rd_aempty(aea));

  dc_fifo_stream #(.DATA_W(W), .DEPTH(DEPTH), .FWFT(1'b0), .OUT_REG(1'b0),
    .AF_OFF(AF), .AE_OFF(AE)) u_dc_fifo_stream_req (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_data(db), .in_valid(vb), .in_ready(rdyb),
    .wr_count(wcb), .wr_afull(afb), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .out_data(odb), .out_valid(ovb), .out_ready(rb), .rd_count(rcb), .rd_aempty(aeb));

  int total = 0, bad = 0;
  int wr_pct = 0, rd_pct = 0, acc_a = 0, acc_b = 0;
  bit run = 0, seen_lag = 0, b_pend = 0, finished = 0;
  logic [W-1:0] qa[$], qb[$];
  logic [W-1:0] b_exp;
  logic [W-1:0] seq = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // write-side reference: checks the state left by the last edge, then offers
  initial forever begin
    @(negedge wr_clk);
    if (run) begin
      chk(int'(wca) >= qa.size(), "R10", "wr_count A lower bound", int'(wca), qa.size());
      chk(int'(wcb) >= qb.size(), "R10", "wr_count B lower bound", int'(wcb), qb.size());
      chk(afa == (int'(wca) >= DEPTH - AF), "R8", "wr_afull A", afa, int'(wca) >= DEPTH - AF);
      chk(afb == (int'(wcb) >= DEPTH - AF), "R8", "wr_afull B", afb, int'(wcb) >= DEPTH - AF);
      chk(rdya == (int'(wca) != DEPTH), "R2", "in_ready A", rdya, int'(wca) != DEPTH);
      chk(rdyb == (int'(wcb) != DEPTH), "R2", "in_ready B", rdyb, int'(wcb) != DEPTH);
      va = (($urandom % 100) < wr_pct);
      vb = (($urandom % 100) < wr_pct);
      seq = seq + 1'b1; da = seq;
      seq = seq + 1'b1; db = seq;
      if (va && rdya) begin qa.push_back(da); acc_a++; end
      if (vb && rdyb) begin qb.push_back(db); acc_b++; end
    end
  end

  // read-side reference for both instances
  initial forever begin
    @(negedge rd_clk);
    if (run) begin
      chk(int'(rca) <= qa.size(), "R11", "rd_count A upper bound", int'(rca), qa.size());
      chk(int'(rcb) <= qb.size(), "R11", "rd_count B upper bound", int'(rcb), qb.size());
      chk(aea == (int'(rca) <= AE), "R9", "rd_aempty A", aea, int'(rca) <= AE);
      chk(aeb == (int'(rcb) <= AE), "R9", "rd_aempty B", aeb, int'(rcb) <= AE);
      if (ova) chk(rca != 0, "R11", "rd_count A with out_valid", int'(rca), 1);
      if (rca != 0 && !ova) seen_lag = 1;
      if (b_pend) chk(odb == b_exp, "R6", "request-mode data", int'(odb), int'(b_exp));
      if (ova) begin
        if (qa.size() == 0) chk(1'b0, "R4", "A word with empty model", int'(oda), -1);
        else chk(oda == qa[0], "R4", "look-ahead order", int'(oda), int'(qa[0]));
      end
      ra = (($urandom % 100) < rd_pct);
      rb = (($urandom % 100) < rd_pct);
      if (ova && ra && qa.size() != 0) void'(qa.pop_front());
      b_pend = 0;
      if (ovb && rb) begin
        if (qb.size() == 0) chk(1'b0, "R4", "B request with empty model", 0, -1);
        else begin b_exp = qb.pop_front(); b_pend = 1; end
      end
    end
  end

  task automatic settle();
    repeat (12) @(negedge rd_clk);
  endtask

  task automatic drain_all();
    wr_pct = 0; rd_pct = 100;
    for (int i = 0; i < 2000 && (qa.size() != 0 || qb.size() != 0 || b_pend); i++)
      @(negedge rd_clk);
    rd_pct = 0;
    settle();
  endtask

  task automatic empty_state(input string tag);
    chk(!ova && !ovb, "R4", {tag, " out_valid after drain"}, ova + ovb, 0);
    chk(rca == 0 && rcb == 0, "R11", {tag, " rd_count after drain"}, int'(rca) + int'(rcb), 0);
    chk(wca == 0 && wcb == 0, "R10", {tag, " wr_count after drain"}, int'(wca) + int'(wcb), 0);
    chk(aea && aeb, "R9", {tag, " rd_aempty after drain"}, aea + aeb, 2);
    chk(!afa && !afb, "R8", {tag, " wr_afull after drain"}, afa + afb, 0);
    chk(rdya && rdyb, "R2", {tag, " in_ready after drain"}, rdya + rdyb, 2);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2ms;
    bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    summary();
  end

  initial begin
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    va = 0; vb = 0; ra = 0; rb = 0; da = '0; db = '0;
    repeat (4) @(negedge rd_clk);
    // R1: state during reset
    chk(!ova && !ovb, "R1", "out_valid in reset", ova + ovb, 0);
    chk(rdya && rdyb, "R1", "in_ready in reset", rdya + rdyb, 2);
    chk(wca == 0 && rca == 0, "R1", "counts in reset", int'(wca) + int'(rca), 0);
    chk(aea && !afa, "R1", "flags in reset", {aea, afa}, 2);
    @(negedge wr_clk); wr_rst_n = 1'b1;
    @(negedge rd_clk); rd_rst_n = 1'b1;
    @(negedge rd_clk);
    chk(!ova && rdya && rca == 0 && wcb == 0, "R1", "state after release", ova, 0);
    run = 1;

    // fill with reads stalled; extra offers while full must be dropped
    acc_a = 0; acc_b = 0; wr_pct = 100; rd_pct = 0;
    repeat (80) @(negedge wr_clk);
    wr_pct = 0;
    settle();
    chk(acc_a == DEPTH, "R7", "words taken with output stage", acc_a, DEPTH);
    chk(acc_b == DEPTH, "R2", "words taken request mode", acc_b, DEPTH);
    chk(acc_a == DEPTH && wca == DEPTH, "R3", "no growth while full", int'(wca), DEPTH);
    chk(!rdya && !rdyb, "R2", "in_ready low when full", rdya + rdyb, 0);
    chk(afa && afb, "R8", "wr_afull when full", afa + afb, 2);
    chk(rca == DEPTH && rcb == DEPTH, "R11", "rd_count when full", int'(rca), DEPTH);
    chk(ova, "R5", "word presented without request", ova, 1);
    chk(ovb, "R6", "request-mode words available", ovb, 1);
    chk(oda == qa[0], "R5", "head word presented", int'(oda), int'(qa[0]));
    chk(seen_lag, "R11", "count ahead of out_valid seen", seen_lag, 1);

    drain_all();
    empty_state("first");

    wr_pct = 60; rd_pct = 50; repeat (3000) @(negedge wr_clk);
    wr_pct = 90; rd_pct = 20; repeat (3000) @(negedge wr_clk);
    wr_pct = 20; rd_pct = 90; repeat (3000) @(negedge wr_clk);
    wr_pct = 100; rd_pct = 100; repeat (2000) @(negedge wr_clk);
    drain_all();
    empty_state("final");
    chk(qa.size() == 0 && qb.size() == 0, "R4", "every word delivered", qa.size() + qb.size(), 0);
    run = 0;
    summary();
  end
endmodule